// File: doc/BRIEF.md
# Five-Source Vectored Interrupt Controller

This block gathers interrupt requests from two external pins, two timer overflow events and a serial port, then filters them through per-source and global enables. It picks one request by fixed priority and presents a 16-bit vector address to the processor. Each external pin is active low. Through a type register, each pin can be used as a level request or as a falling-edge request. In edge mode a latched flag holds the event.

The processor accepts a request by pulsing an acknowledge input while the request is shown. The controller then enters an in-service state and takes no new request until a return pulse arrives. On acceptance it clears the flags that hardware owns: the edge flags and the timer flags. The two serial flags are left for software to clear. Software can write the whole flag vector at any time, which raises requests or cancels pending ones exactly as hardware events do.

Top module: `intr_vec_ctrl`

## Requirements
- R1: After reset, all flags are 0, all enables are 0, both external inputs are in level mode, `in_service` is 0 and `irq_req` is 0.
- R2: Enable bit 7 is the global enable. While it is 0, `irq_req` stays 0 whatever is pending.
- R3: Enable bits 0..4 gate, in order, external 0, timer 0, external 1, timer 1 and serial. A source whose bit is 0 raises no request. Enable bits 6 and 5 have no effect.
- R4: The vector for each source is fixed: external 0 is 0x0003, timer 0 is 0x000B, external 1 is 0x0013, timer 1 is 0x001B and serial is 0x0023.
- R5: When several enabled requests are pending, the one with the lowest vector is presented.
- R6: With type bit 0 set to 0 (level mode), the request for external 0 is active exactly while `ext_n[0]` is low, and no flag is latched. Type bit 1 and `ext_n[1]` behave the same way for external 1.
- R7: With a type bit set to 1 (edge mode), a high-to-low transition on the pin sets that input's flag one clock later. The flag stays set after the pin returns high. A pin held low produces no second event.
- R8: `irq_ack` while `irq_req` is 1 sets `in_service` on the next cycle. It also clears the flag of the presented source if that source is an external input or a timer.
- R9: The serial request is the OR of the rx flag (flag bit 4) and the tx flag (flag bit 5). Acceptance does not clear either flag.
- R10: While `in_service` is 1, `irq_req` is 0 and `irq_ack` is ignored. A `reti` pulse clears `in_service` on the next cycle.
- R11: The flag vector has this layout: bit 0 external 0, bit 1 timer 0, bit 2 external 1, bit 3 timer 1, bit 4 serial rx, bit 5 serial tx. A software write replaces the whole vector and takes precedence over a hardware event in the same cycle.
- R12: A hardware event that arrives in the same cycle as the acceptance that would clear its flag leaves that flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_n | input | 2 | External request pins, active low |
| tmr_ovf | input | 2 | Timer overflow event pulses (bit 0 timer 0, bit 1 timer 1) |
| ser_rx_done | input | 1 | Serial receive-complete pulse |
| ser_tx_done | input | 1 | Serial transmit-complete pulse |
| en_we | input | 1 | Enable register write strobe |
| en_wdata | input | 8 | Enable register write data |
| type_we | input | 1 | Trigger type register write strobe |
| type_wdata | input | 2 | Trigger type per external input, 1 selects falling edge |
| flg_we | input | 1 | Flag vector write strobe |
| flg_wdata | input | 6 | Flag vector write data |
| flags_q | output | 6 | Current flag vector |
| irq_ack | input | 1 | Processor accepts the presented request |
| reti | input | 1 | Return from service pulse |
| irq_req | output | 1 | A request is presented |
| irq_vec | output | 16 | Vector address of the presented request |
| in_service | output | 1 | A request is being serviced |

## Verification
A wrong flag shows up on `flags_q` one clock after the event or write that caused it. On `irq_req` and `irq_vec` it shows up combinationally, in the same cycle. A stuck or missing in-service state becomes visible on the cycle after an acknowledge or return pulse: a second request appears too early, or the controller stays silent. Priority or mask faults appear directly as a wrong vector, or as a missing request, as soon as two sources are pending together.

// File: rtl/intr_pkg.sv
package intr_pkg;

    localparam int NUM_SRC  = 5;
    localparam int NUM_EXT  = 2;
    localparam int NUM_FLG  = 6;
    localparam int IDX_W    = $clog2(NUM_SRC);
    localparam int VEC_W    = 16;
    localparam int GIE_BIT  = 7;

    localparam logic [VEC_W-1:0] VEC_BASE = 16'h0003;

    typedef enum logic [IDX_W-1:0] {
        SRC_EX0 = 3'd0,
        SRC_TM0 = 3'd1,
        SRC_EX1 = 3'd2,
        SRC_TM1 = 3'd3,
        SRC_SER = 3'd4
    } src_e;

    typedef struct packed {
        logic tx;
        logic rx;
        logic tm1;
        logic ex1;
        logic tm0;
        logic ex0;
    } flag_t;

    function automatic logic [VEC_W-1:0] vec_of(input logic [IDX_W-1:0] idx);
        return VEC_BASE + {{(VEC_W-IDX_W-3){1'b0}}, idx, 3'b000};
    endfunction

endpackage

// File: rtl/intr_edge_det.sv
module intr_edge_det #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] pin_n,
    output logic [N-1:0] fall_o
);
    logic [N-1:0] prev_q;

    for (genvar i = 0; i < N; i++) begin : g_det
        always_ff @(posedge clk) begin
            if (rst) prev_q[i] <= 1'b1;
            else     prev_q[i] <= pin_n[i];
        end
        assign fall_o[i] = prev_q[i] & ~pin_n[i];
    end

    AST_FALL_NEEDS_HIGH: assert property (@(posedge clk) disable iff (rst)
        fall_o[0] |-> $past(pin_n[0])); // R7
endmodule

// File: rtl/intr_flag_bank.sv
module intr_flag_bank
    import intr_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_EXT-1:0] ext_fall,
    input  logic [NUM_EXT-1:0] edge_mode,
    input  logic [1:0]         tmr_set,
    input  logic               rx_set,
    input  logic               tx_set,
    input  logic               sw_we,
    input  flag_t              sw_data,
    input  flag_t              ack_clr,
    output flag_t              flags_o
);
    flag_t set_v;
    flag_t flg_q;

    always_comb begin
        set_v     = '0;
        set_v.ex0 = ext_fall[0] & edge_mode[0];
        set_v.ex1 = ext_fall[1] & edge_mode[1];
        set_v.tm0 = tmr_set[0];
        set_v.tm1 = tmr_set[1];
        set_v.rx  = rx_set;
        set_v.tx  = tx_set;
    end

    always_ff @(posedge clk) begin
        if (rst)        flg_q <= '0;
        else if (sw_we) flg_q <= sw_data;
        else            flg_q <= (flg_q & ~ack_clr) | set_v;
    end

    assign flags_o = flg_q;

    AST_SW_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
        sw_we |=> flags_o == $past(sw_data)); // R11
    AST_SET_OVER_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (!sw_we && tmr_set[0] && ack_clr.tm0) |=> flags_o.tm0); // R12
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (!sw_we && ack_clr.tm1 && !tmr_set[1]) |=> !flags_o.tm1); // R8
    AST_LEVEL_NO_LATCH: assert property (@(posedge clk) disable iff (rst)
        (!sw_we && !edge_mode[0] && !flags_o.ex0) |=> !flags_o.ex0); // R6
endmodule

// File: rtl/intr_prio_sel.sv
module intr_prio_sel
    import intr_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input  logic [N-1:0]     pend,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o,
    output logic [N-1:0]     grant_o
);
    always_comb begin
        idx_o   = '0;
        grant_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend[i]) begin
                idx_o   = IDX_W'(i);
                grant_o = N'(1) << i;
            end
        end
        any_o = |pend;
    end

    always_comb begin
        AST_ONE_GRANT: assert (!any_o || $countones(grant_o) == 1); // R5
        AST_LOWEST_WINS: assert (!any_o || (pend & (grant_o - N'(1))) == '0); // R5
    end
endmodule

// File: rtl/intr_vec_ctrl.sv
module intr_vec_ctrl
    import intr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  ext_n,
    input  logic [1:0]  tmr_ovf,
    input  logic        ser_rx_done,
    input  logic        ser_tx_done,
    input  logic        en_we,
    input  logic [7:0]  en_wdata,
    input  logic        type_we,
    input  logic [1:0]  type_wdata,
    input  logic        flg_we,
    input  logic [5:0]  flg_wdata,
    output logic [5:0]  flags_q,
    input  logic        irq_ack,
    input  logic        reti,
    output logic        irq_req,
    output logic [15:0] irq_vec,
    output logic        in_service
);
    logic [NUM_SRC-1:0] src_en_q;
    logic               gie_q;
    logic [NUM_EXT-1:0] type_q;
    logic               insvc_q;
    logic [NUM_EXT-1:0] ext_fall;
    flag_t              flags;
    flag_t              clr_v;
    logic [NUM_SRC-1:0] pend;
    logic [NUM_SRC-1:0] grant;
    logic [IDX_W-1:0]   sel_idx;
    logic               any_pend;
    logic               accept;
    logic               unused_rsvd;

    assign unused_rsvd = ^en_wdata[6:5];

    always_ff @(posedge clk) begin
        if (rst) begin
            src_en_q <= '0;
            gie_q    <= 1'b0;
            type_q   <= '0;
        end else begin
            if (en_we) begin
                src_en_q <= en_wdata[NUM_SRC-1:0];
                gie_q    <= en_wdata[GIE_BIT];
            end
            if (type_we) type_q <= type_wdata;
        end
    end

    intr_edge_det #(.N(NUM_EXT)) u_edge (
        .clk    (clk),
        .rst    (rst),
        .pin_n  (ext_n),
        .fall_o (ext_fall)
    );

    intr_flag_bank u_flags (
        .clk       (clk),
        .rst       (rst),
        .ext_fall  (ext_fall),
        .edge_mode (type_q),
        .tmr_set   (tmr_ovf),
        .rx_set    (ser_rx_done),
        .tx_set    (ser_tx_done),
        .sw_we     (flg_we),
        .sw_data   (flag_t'(flg_wdata)),
        .ack_clr   (clr_v),
        .flags_o   (flags)
    );

    always_comb begin
        pend          = '0;
        pend[SRC_EX0] = type_q[0] ? flags.ex0 : ~ext_n[0];
        pend[SRC_TM0] = flags.tm0;
        pend[SRC_EX1] = type_q[1] ? flags.ex1 : ~ext_n[1];
        pend[SRC_TM1] = flags.tm1;
        pend[SRC_SER] = flags.rx | flags.tx;
        pend          = pend & src_en_q & {NUM_SRC{gie_q}};
    end

    intr_prio_sel #(.N(NUM_SRC)) u_sel (
        .pend    (pend),
        .any_o   (any_pend),
        .idx_o   (sel_idx),
        .grant_o (grant)
    );

    assign irq_req = any_pend & ~insvc_q;
    assign accept  = irq_ack & irq_req;
    assign irq_vec = vec_of(sel_idx);

    always_comb begin
        clr_v = '0;
        if (accept) begin
            clr_v.ex0 = grant[SRC_EX0];
            clr_v.tm0 = grant[SRC_TM0];
            clr_v.ex1 = grant[SRC_EX1];
            clr_v.tm1 = grant[SRC_TM1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         insvc_q <= 1'b0;
        else if (accept) insvc_q <= 1'b1;
        else if (reti)   insvc_q <= 1'b0;
    end

    assign in_service = insvc_q;
    assign flags_q    = flags;

    AST_ACCEPT_ENTERS: assert property (@(posedge clk) disable iff (rst)
        (irq_ack && irq_req) |=> in_service); // R8
    AST_RETI_LEAVES: assert property (@(posedge clk) disable iff (rst)
        (reti && !irq_req) |=> !in_service); // R10
    AST_VEC_SHAPE: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (irq_vec[2:0] == 3'b011 && irq_vec < 16'h0028)); // R4
    AST_GLOBAL_OFF: assert property (@(posedge clk) disable iff (rst)
        (en_we && !en_wdata[GIE_BIT]) |=> !irq_req); // R2
    AST_SERIAL_KEPT: assert property (@(posedge clk) disable iff (rst)
        (accept && grant[SRC_SER] && !flg_we) |=> (flags_q[4] || flags_q[5])); // R9
endmodule

// File: tb/intr_vec_ctrl_test.sv
module intr_vec_ctrl_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  ext_n = 2'b11;
    logic [1:0]  tmr_ovf = '0;
    logic        ser_rx_done = 1'b0, ser_tx_done = 1'b0;
    logic        en_we = 1'b0, type_we = 1'b0, flg_we = 1'b0;
    logic [7:0]  en_wdata = '0;
    logic [1:0]  type_wdata = '0;
    logic [5:0]  flg_wdata = '0;
    logic [5:0]  flags_q;
    logic        irq_ack = 1'b0, reti = 1'b0;
    logic        irq_req, in_service;
    logic [15:0] irq_vec;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    intr_vec_ctrl uut (
        .clk(clk), .rst(rst), .ext_n(ext_n), .tmr_ovf(tmr_ovf),
        .ser_rx_done(ser_rx_done), .ser_tx_done(ser_tx_done),
        .en_we(en_we), .en_wdata(en_wdata), .type_we(type_we),
        .type_wdata(type_wdata), .flg_we(flg_we), .flg_wdata(flg_wdata),
        .flags_q(flags_q), .irq_ack(irq_ack), .reti(reti),
        .irq_req(irq_req), .irq_vec(irq_vec), .in_service(in_service)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr_en(input logic [7:0] v);
        en_we = 1'b1; en_wdata = v; step(); en_we = 1'b0;
    endtask

    task automatic wr_type(input logic [1:0] v);
        type_we = 1'b1; type_wdata = v; step(); type_we = 1'b0;
    endtask

    task automatic wr_flags(input logic [5:0] v);
        flg_we = 1'b1; flg_wdata = v; step(); flg_we = 1'b0;
    endtask

    task automatic do_ack();
        irq_ack = 1'b1; step(); irq_ack = 1'b0;
    endtask

    task automatic do_reti();
        reti = 1'b1; step(); reti = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 flags", 32'(flags_q), 0);
        check("R1 irq_req", 32'(irq_req), 0);
        check("R1 in_service", 32'(in_service), 0);
        wr_flags(6'b000010);
        check("R1 enables zero", 32'(irq_req), 0);
        wr_flags(6'b000000);
    endtask

    task automatic t_global();
        wr_en(8'h1F);
        wr_flags(6'b000010);
        check("R2 global off", 32'(irq_req), 0);
        wr_en(8'h82);
        check("R2 global on req", 32'(irq_req), 1);
        check("R4 tm0 vector", 32'(irq_vec), 32'h000B);
        wr_en(8'hE0);
        check("R3 reserved bits no effect", 32'(irq_req), 0);
        wr_en(8'h9D);
        check("R3 tm0 masked", 32'(irq_req), 0);
        wr_flags(6'b000000);
    endtask

    task automatic t_prio();
        wr_type(2'b11);
        wr_en(8'h9F);
        wr_flags(6'b111111);
        check("R5 all pending", 32'(irq_vec), 32'h0003);
        wr_flags(6'b111110);
        check("R5 ex0 gone", 32'(irq_vec), 32'h000B);
        wr_flags(6'b111100);
        check("R4 ex1 vector", 32'(irq_vec), 32'h0013);
        wr_flags(6'b111000);
        check("R4 tm1 vector", 32'(irq_vec), 32'h001B);
        wr_flags(6'b110000);
        check("R4 serial vector", 32'(irq_vec), 32'h0023);
        wr_flags(6'b100000);
        check("R9 tx alone req", 32'(irq_req), 1);
        wr_flags(6'b010000);
        check("R9 rx alone req", 32'(irq_req), 1);
        wr_flags(6'b000000);
        check("R11 cancel by write", 32'(irq_req), 0);
    endtask

    task automatic t_ack();
        wr_flags(6'b011011);
        check("R8 first vector", 32'(irq_vec), 32'h0003);
        do_ack();
        check("R8 in_service set", 32'(in_service), 1);
        check("R10 no req in service", 32'(irq_req), 0);
        check("R8 ex0 flag cleared", 32'(flags_q), 32'h1A);
        do_ack();
        check("R10 ack ignored in service", 32'(flags_q), 32'h1A);
        do_reti();
        check("R10 reti clears", 32'(in_service), 0);
        check("R8 next vector", 32'(irq_vec), 32'h000B);
        do_ack();
        check("R8 tm0 cleared", 32'(flags_q), 32'h18);
        do_reti();
        check("R8 tm1 vector", 32'(irq_vec), 32'h001B);
        do_ack();
        check("R8 tm1 cleared", 32'(flags_q), 32'h10);
        do_reti();
        check("R9 serial vector", 32'(irq_vec), 32'h0023);
        do_ack();
        check("R9 serial flags kept", 32'(flags_q), 32'h10);
        check("R8 serial in service", 32'(in_service), 1);
        do_reti();
        check("R9 serial still requests", 32'(irq_req), 1);
        wr_flags(6'b000000);
        check("R11 software clear", 32'(irq_req), 0);
    endtask

    task automatic t_level();
        wr_type(2'b00);
        wr_en(8'h85);
        ext_n = 2'b10; #1;
        check("R6 ex0 level req", 32'(irq_req), 1);
        check("R6 ex0 level vector", 32'(irq_vec), 32'h0003);
        step();
        check("R6 no flag latched", 32'(flags_q), 0);
        ext_n = 2'b00; #1;
        check("R5 ex0 over ex1", 32'(irq_vec), 32'h0003);
        ext_n = 2'b01; #1;
        check("R6 ex1 level vector", 32'(irq_vec), 32'h0013);
        ext_n = 2'b11; #1;
        check("R6 released", 32'(irq_req), 0);
        step();
        check("R6 no flag after release", 32'(flags_q), 0);
    endtask

    task automatic t_edge();
        wr_type(2'b01);
        wr_en(8'h81);
        ext_n = 2'b10;
        step();
        check("R7 edge flag set", 32'(flags_q), 32'h01);
        check("R7 edge vector", 32'(irq_vec), 32'h0003);
        step();
        do_ack();
        check("R8 edge flag cleared", 32'(flags_q), 0);
        step();
        check("R7 held low no new edge", 32'(flags_q), 0);
        do_reti();
        check("R7 no req after service", 32'(irq_req), 0);
        ext_n = 2'b11;
        step();
        check("R7 rising no flag", 32'(flags_q), 0);
        ext_n = 2'b10; step(); ext_n = 2'b11; step();
        check("R7 flag held after pulse", 32'(flags_q), 32'h01);
        wr_flags(6'b000000);
    endtask

    task automatic t_hw_events();
        wr_en(8'h9A);
        tmr_ovf = 2'b10; step(); tmr_ovf = 2'b00;
        check("R11 tm1 hw set bit3", 32'(flags_q), 32'h08);
        ser_rx_done = 1'b1; step(); ser_rx_done = 1'b0;
        check("R11 rx hw set bit4", 32'(flags_q), 32'h18);
        check("R5 tm1 over serial", 32'(irq_vec), 32'h001B);
        ser_tx_done = 1'b1; step(); ser_tx_done = 1'b0;
        check("R11 tx hw set bit5", 32'(flags_q), 32'h38);
        tmr_ovf = 2'b01; flg_we = 1'b1; flg_wdata = 6'b000000;
        step();
        tmr_ovf = 2'b00; flg_we = 1'b0;
        check("R11 write beats hw", 32'(flags_q), 0);
        wr_flags(6'b000010);
        irq_ack = 1'b1; tmr_ovf = 2'b01;
        step();
        irq_ack = 1'b0; tmr_ovf = 2'b00;
        check("R12 set beats clear", 32'(flags_q), 32'h02);
        check("R12 accepted", 32'(in_service), 1);
        do_reti();
        wr_flags(6'b000000);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_global();
        t_prio();
        t_ack();
        t_level();
        t_edge();
        t_hw_events();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule